// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave Front End

This block sits between a microcontroller bus that shares its low address byte with its data byte and the storage core of a byte-wide memory peripheral. A latch strobe loads a 15-bit address: the low eight bits come from the shared lines and the upper seven bits from dedicated lines. The address follows the pins while the strobe is high and is held once the strobe falls. After that the shared lines carry data.

An active-low chip enable gates everything. With the chip selected, either the program-fetch strobe or the data-read strobe starts a read. During a read the block turns on its output enable and drives the byte that the core returns for the held address. A write strobe with both read strobes idle is a write. Its data is taken from the shared lines as the strobe is released, and it reaches the core as a one-cycle pulse together with the held address. If a read strobe and the write strobe are low at the same time, the cycle is a conflict: the block does not drive the bus and does not issue a write.

Every pin is synchronised to the fast system clock through a configurable number of flop stages. Reset is asynchronous on assertion and is released in step with the clock.

Top module: `mbus_slave_if`

## Requirements
- R1: While reset is applied and right after it, `ad_oe_o` is 0, `ad_o` is 0, `wr_pulse_o` is 0 and `standby_o` is 1.
- R2: While `ce_n_i` is 1, `standby_o` is 1 and `ad_oe_o` is 0, and a write strobe issues no `wr_pulse_o`.
- R3: While `ale_i` is 1, `core_addr_o` equals {`ahi_i`, `ad_i`}, with `ahi_i` as bits 14:8 and `ad_i` as bits 7:0, and it follows the pins within 3 clock cycles.
- R4: After `ale_i` falls, `core_addr_o` keeps the last address captured while `ale_i` was high, even when `ad_i` changes.
- R5: With `ce_n_i` 0 and `wr_n_i` 1, `pfetch_n_i` at 0 sets `ad_oe_o` to 1 and `ad_o` to `core_rdata_i` by the third rising clock edge.
- R6: With `ce_n_i` 0 and `wr_n_i` 1, `rd_n_i` at 0 gives the same read. `ad_oe_o` returns to 0 by the third rising edge after the strobe is released.
- R7: A write strobe (`wr_n_i` low with `ce_n_i` 0 and both read strobes 1) gives exactly one `wr_pulse_o`, one cycle wide, during the cycle after the third rising edge following the release of `wr_n_i`.
- R8: With `wr_pulse_o`, `wr_addr_o` is the held address and `wr_data_o` is the last value on `ad_i` before `wr_n_i` rose, including when `ad_i` changes during the low phase.
- R9: If `wr_n_i` is low while `rd_n_i` or `pfetch_n_i` is low, `ad_oe_o` stays 0 and no `wr_pulse_o` follows that write strobe.
- R10: With `ce_n_i` 0 and all three strobes 1, `ad_oe_o` is 0 and `standby_o` is 0, and `ad_oe_o` is 0 throughout a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale_i | input | 1 | Address latch strobe, high = pass address through |
| ce_n_i | input | 1 | Chip enable, active low |
| pfetch_n_i | input | 1 | Program-fetch read strobe, active low |
| rd_n_i | input | 1 | Data read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| ad_i | input | 8 | Shared address/data lines, input side |
| ahi_i | input | 7 | Dedicated upper address lines |
| ad_o | output | 8 | Shared lines, output side |
| ad_oe_o | output | 1 | Output enable for the shared lines |
| standby_o | output | 1 | High while the chip is deselected |
| core_addr_o | output | 15 | Address presented to the storage core |
| core_rdata_i | input | 8 | Byte returned by the core for `core_addr_o` |
| wr_pulse_o | output | 1 | One-cycle write request to the core |
| wr_addr_o | output | 15 | Write address, valid with `wr_pulse_o` |
| wr_data_o | output | 8 | Write data, valid with `wr_pulse_o` |

## Verification
A stuck or mis-armed write qualifier shows up as a missing or extra `wr_pulse_o`. The scoreboard catches this about three cycles after the write strobe is released. A held address that leaks through after the latch strobe falls shows up as a wrong `core_addr_o` and wrong read data as soon as the shared lines carry data, which is two cycles later. A wrong decode of the strobes shows up at `ad_oe_o` by the third edge after the strobe changes: it drives during standby, during a conflict or during a write, or it fails to drive during a fetch or a read.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  // Bus cycle class decoded from the synchronised strobes
  typedef enum logic [2:0] {
    CYC_STANDBY = 3'd0,
    CYC_IDLE    = 3'd1,
    CYC_READ    = 3'd2,
    CYC_WRITE   = 3'd3,
    CYC_CLASH   = 3'd4
  } cyc_e;

endpackage

// File: rtl/mbus_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pins.
module mbus_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [STAGES-1:0][W-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = din;
    for (int s = 1; s < STAGES; s++) begin
      pipe_d[s] = pipe_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        pipe_q[s] <= RST_VAL;
      end
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/mbus_addr_latch.sv
// Transparent address latch built from a clocked hold register.
module mbus_addr_latch #(
  parameter int LO_W = 8,
  parameter int HI_W = 7,
  localparam int A_W = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale_s,
  input  logic [LO_W-1:0] lo_s,
  input  logic [HI_W-1:0] hi_s,
  output logic [A_W-1:0]  addr_o
);

  logic [A_W-1:0] addr_q;
  logic [A_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (ale_s) begin
      addr_d = {hi_s, lo_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (ale_s) begin
      addr_q <= addr_d;
    end
  end

  assign addr_o = addr_d;

  // R4: once the strobe has been low for a cycle the address does not move
  p_addr_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale_s && !$past(ale_s)) |-> $stable(addr_o));

  // R3: while the strobe is high the pins flow straight through
  p_addr_flow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale_s |-> (addr_o == {hi_s, lo_s}));

endmodule

// File: rtl/mbus_cycle_dec.sv
// Strobe decode and read-side bus drive.
module mbus_cycle_dec
  import mbus_pkg::*;
#(
  parameter int D_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce_n_s,
  input  logic           pf_n_s,
  input  logic           rd_n_s,
  input  logic           wr_n_s,
  input  logic [D_W-1:0] rdata_i,
  output cyc_e           cyc_o,
  output logic           oe_o,
  output logic [D_W-1:0] dout_o,
  output logic           standby_o
);

  logic           rd_any;
  cyc_e           cyc;
  logic           oe_q, oe_d;
  logic           stby_q, stby_d;
  logic [D_W-1:0] dout_q, dout_d;
  logic           dout_en;

  always_comb begin
    rd_any = !pf_n_s || !rd_n_s;
    if (ce_n_s) begin
      cyc = CYC_STANDBY;
    end else if (rd_any && !wr_n_s) begin
      cyc = CYC_CLASH;
    end else if (rd_any) begin
      cyc = CYC_READ;
    end else if (!wr_n_s) begin
      cyc = CYC_WRITE;
    end else begin
      cyc = CYC_IDLE;
    end
  end

  always_comb begin
    oe_d    = (cyc == CYC_READ);
    stby_d  = (cyc == CYC_STANDBY);
    dout_en = oe_d || oe_q;
    dout_d  = oe_d ? rdata_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      stby_q <= 1'b1;
    end else begin
      oe_q   <= oe_d;
      stby_q <= stby_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else if (dout_en) begin
      dout_q <= dout_d;
    end
  end

  assign cyc_o     = cyc;
  assign oe_o      = oe_q;
  assign dout_o    = dout_q;
  assign standby_o = stby_q;

  // R2: a deselected chip never drives the shared lines
  p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n_s) |-> (!oe_o && standby_o));

  // R9: a read/write conflict never drives the shared lines
  p_clash_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cyc) == CYC_CLASH) |-> !oe_o);

  // R10: the shared lines are inputs while the write strobe is low
  p_no_drive_in_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!wr_n_s) |-> !oe_o);

endmodule

// File: rtl/mbus_wr_capture.sv
// Write-strobe edge detect, data capture and one-cycle core write request.
module mbus_wr_capture #(
  parameter int A_W = 15,
  parameter int D_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_n_s,
  input  logic           is_write,
  input  logic [D_W-1:0] data_s,
  input  logic [A_W-1:0] addr_i,
  output logic           pulse_o,
  output logic [A_W-1:0] waddr_o,
  output logic [D_W-1:0] wdata_o
);

  logic           wr_prev_q;
  logic           armed_q, armed_d;
  logic [D_W-1:0] data_q;
  logic           data_en;
  logic           wr_rise;
  logic           pulse_q, pulse_d;
  logic [A_W-1:0] waddr_q;
  logic [D_W-1:0] wdata_q;

  always_comb begin
    wr_rise = wr_n_s && !wr_prev_q;
    data_en = !wr_n_s;
    // armed stays set only if every low cycle of the strobe decoded as a write
    armed_d = wr_n_s ? 1'b1 : (armed_q && is_write);
    pulse_d = wr_rise && armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev_q <= 1'b1;
      armed_q   <= 1'b1;
      pulse_q   <= 1'b0;
    end else begin
      wr_prev_q <= wr_n_s;
      armed_q   <= armed_d;
      pulse_q   <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      wdata_q <= '0;
    end else if (pulse_d) begin
      waddr_q <= addr_i;
      wdata_q <= data_q;
    end
  end

  assign pulse_o = pulse_q;
  assign waddr_o = waddr_q;
  assign wdata_o = wdata_q;

  // R7: the write request lasts exactly one cycle
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  // R7: a request follows a release of the write strobe one cycle earlier
  p_pulse_after_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> ($past(wr_n_s) && !$past(wr_n_s, 2)));

  // R9: a request needs a clean write decode on the last low cycle
  p_pulse_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> $past(is_write, 2));

endmodule

// File: rtl/mbus_slave_if.sv
// Multiplexed address/data bus slave front end.
module mbus_slave_if
  import mbus_pkg::*;
#(
  parameter int LO_W        = 8,
  parameter int HI_W        = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ale_i,
  input  logic                   ce_n_i,
  input  logic                   pfetch_n_i,
  input  logic                   rd_n_i,
  input  logic                   wr_n_i,
  input  logic [LO_W-1:0]        ad_i,
  input  logic [HI_W-1:0]        ahi_i,
  output logic [LO_W-1:0]        ad_o,
  output logic                   ad_oe_o,
  output logic                   standby_o,
  output logic [LO_W+HI_W-1:0]   core_addr_o,
  input  logic [LO_W-1:0]        core_rdata_i,
  output logic                   wr_pulse_o,
  output logic [LO_W+HI_W-1:0]   wr_addr_o,
  output logic [LO_W-1:0]        wr_data_o
);

  localparam int A_W     = LO_W + HI_W;
  localparam int N_STB   = 5;
  localparam logic [N_STB-1:0] STB_IDLE = 5'b01111;

  // reset: asserted at once, released through two flops
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic rst_n_int;
  assign rst_n_int = rst_sync_q;

  // strobes and buses pass through matching synchroniser depths
  logic [N_STB-1:0] stb_s;
  logic [A_W-1:0]   bus_s;

  mbus_sync #(.W(N_STB), .STAGES(SYNC_STAGES), .RST_VAL(STB_IDLE)) u_stb_sync (
    .clk  (clk),
    .rst_n(rst_n_int),
    .din  ({ale_i, ce_n_i, pfetch_n_i, rd_n_i, wr_n_i}),
    .dout (stb_s)
  );

  mbus_sync #(.W(A_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk  (clk),
    .rst_n(rst_n_int),
    .din  ({ahi_i, ad_i}),
    .dout (bus_s)
  );

  logic            ale_s, ce_n_s, pf_n_s, rd_n_s, wr_n_s;
  logic [LO_W-1:0] lo_s;
  logic [HI_W-1:0] hi_s;

  assign {ale_s, ce_n_s, pf_n_s, rd_n_s, wr_n_s} = stb_s;
  assign {hi_s, lo_s} = bus_s;

  logic [A_W-1:0] addr;

  mbus_addr_latch #(.LO_W(LO_W), .HI_W(HI_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_n_int),
    .ale_s (ale_s),
    .lo_s  (lo_s),
    .hi_s  (hi_s),
    .addr_o(addr)
  );

  cyc_e cyc;

  mbus_cycle_dec #(.D_W(LO_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .ce_n_s   (ce_n_s),
    .pf_n_s   (pf_n_s),
    .rd_n_s   (rd_n_s),
    .wr_n_s   (wr_n_s),
    .rdata_i  (core_rdata_i),
    .cyc_o    (cyc),
    .oe_o     (ad_oe_o),
    .dout_o   (ad_o),
    .standby_o(standby_o)
  );

  mbus_wr_capture #(.A_W(A_W), .D_W(LO_W)) u_wr (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_n_s  (wr_n_s),
    .is_write(cyc == CYC_WRITE),
    .data_s  (lo_s),
    .addr_i  (addr),
    .pulse_o (wr_pulse_o),
    .waddr_o (wr_addr_o),
    .wdata_o (wr_data_o)
  );

  assign core_addr_o = addr;

  // R1/R10: the bus is never driven in the same cycle as a write request
  p_drive_vs_write_r10: assert property (@(posedge clk) disable iff (!rst_n_int)
    wr_pulse_o |-> !ad_oe_o);

endmodule

// File: tb/mbus_slave_if_tb.sv
module mbus_slave_if_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ale, ce_n, pf_n, rd_n, wr_n;
  logic [7:0]  ad_in;
  logic [6:0]  ahi;
  logic [7:0]  ad_out;
  logic        oe, stby;
  logic [14:0] caddr;
  logic [7:0]  crdata;
  logic        wpulse;
  logic [14:0] waddr;
  logic [7:0]  wdata;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  int cycles = 0;
  logic [22:0] exp_q[$];

  always #2 clk = ~clk;  // 250 MHz

  // core model: a fixed function of the address
  function automatic logic [7:0] core_byte(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  assign crdata = core_byte(caddr);

  mbus_slave_if u_dut (
    .clk(clk), .rst_n(rst_n), .ale_i(ale), .ce_n_i(ce_n), .pfetch_n_i(pf_n),
    .rd_n_i(rd_n), .wr_n_i(wr_n), .ad_i(ad_in), .ahi_i(ahi), .ad_o(ad_out),
    .ad_oe_o(oe), .standby_o(stby), .core_addr_o(caddr), .core_rdata_i(crdata),
    .wr_pulse_o(wpulse), .wr_addr_o(waddr), .wr_data_o(wdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected write items as requests appear
  always @(negedge clk) begin
    if (rst_n && wpulse) begin
      pulses++;
      if (exp_q.size() == 0) begin
        chk("R7 unexpected write request", 32'd1, 32'd0);
      end else begin
        logic [22:0] e;
        e = exp_q.pop_front();
        chk("R8 write address", {17'd0, waddr}, {17'd0, e[22:8]});
        chk("R8 write data", {24'd0, wdata}, {24'd0, e[7:0]});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog act=%0d exp=%0d", cycles, 50000);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic latch_addr(input logic [14:0] a);
    ale = 1'b1; ad_in = a[7:0]; ahi = a[14:8];
    cyc(4);
    chk("R3 address flows while latch strobe high", {17'd0, caddr}, {17'd0, a});
    ale = 1'b0;
    cyc(3);
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d, input logic [7:0] early);
    int p0;
    p0 = pulses;
    latch_addr(a);
    ad_in = early;
    wr_n = 1'b0;
    cyc(3);
    chk("R4 address held while lines carry data", {17'd0, caddr}, {17'd0, a});
    chk("R10 no drive during write", {31'd0, oe}, 32'd0);
    ad_in = d;
    cyc(3);
    exp_q.push_back({a, d});
    wr_n = 1'b1;
    cyc(1);
    ad_in = ~d;
    cyc(1);
    chk("R7 no request before third edge", {31'd0, wpulse}, 32'd0);
    cyc(1);
    chk("R7 request after third edge", {31'd0, wpulse}, 32'd1);
    cyc(1);
    chk("R7 request one cycle wide", {31'd0, wpulse}, 32'd0);
    cyc(3);
    chk("R7 one request per strobe", pulses - p0, 32'd1);
  endtask

  task automatic do_read(input logic [14:0] a, input bit fetch);
    latch_addr(a);
    ad_in = 8'hC3;
    if (fetch) pf_n = 1'b0; else rd_n = 1'b0;
    cyc(2);
    chk(fetch ? "R5 fetch not yet driving" : "R6 read not yet driving", {31'd0, oe}, 32'd0);
    cyc(1);
    chk(fetch ? "R5 fetch drives" : "R6 read drives", {31'd0, oe}, 32'd1);
    chk(fetch ? "R5 fetch data" : "R6 read data", {24'd0, ad_out}, {24'd0, core_byte(a)});
    chk("R4 address held during read", {17'd0, caddr}, {17'd0, a});
    pf_n = 1'b1; rd_n = 1'b1;
    cyc(3);
    chk("R6 drive released", {31'd0, oe}, 32'd0);
    cyc(1);
  endtask

  initial begin
    int p0;
    rst_n = 1'b0;
    ale = 1'b0; ce_n = 1'b1; pf_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    ad_in = 8'h00; ahi = 7'h00;
    cyc(3);
    chk("R1 reset oe", {31'd0, oe}, 32'd0);
    chk("R1 reset data", {24'd0, ad_out}, 32'd0);
    chk("R1 reset pulse", {31'd0, wpulse}, 32'd0);
    chk("R1 reset standby", {31'd0, stby}, 32'd1);
    rst_n = 1'b1;
    cyc(6);
    chk("R1 after reset oe", {31'd0, oe}, 32'd0);
    chk("R2 deselected standby", {31'd0, stby}, 32'd1);

    // R2: strobes while deselected
    p0 = pulses;
    latch_addr(15'h1234);
    rd_n = 1'b0;
    cyc(4);
    chk("R2 read ignored when deselected", {31'd0, oe}, 32'd0);
    rd_n = 1'b1;
    wr_n = 1'b0; ad_in = 8'h77;
    cyc(4);
    wr_n = 1'b1;
    cyc(5);
    chk("R2 write ignored when deselected", pulses - p0, 32'd0);

    ce_n = 1'b0;
    cyc(4);
    chk("R10 idle not standby", {31'd0, stby}, 32'd0);
    chk("R10 idle no drive", {31'd0, oe}, 32'd0);

    // R3: transparency tracks changing pins
    ale = 1'b1; ad_in = 8'h11; ahi = 7'h22;
    cyc(3);
    chk("R3 first value", {17'd0, caddr}, {17'd0, 15'h2211});
    ad_in = 8'hEE; ahi = 7'h5D;
    cyc(3);
    chk("R3 follows new value", {17'd0, caddr}, {17'd0, 15'h5DEE});
    ale = 1'b0;
    cyc(2);

    do_read(15'h0000, 1'b1);
    do_read(15'h7FFF, 1'b0);
    do_read(15'h2A55, 1'b1);
    do_read(15'h5580, 1'b0);

    do_write(15'h5555, 8'hAA, 8'h00);
    do_write(15'h2AAA, 8'h55, 8'hFF);
    do_write(15'h7F80, 8'h01, 8'h3C);
    do_write(15'h0001, 8'hFE, 8'hFE);

    // R9: read and write together
    p0 = pulses;
    latch_addr(15'h4321);
    rd_n = 1'b0; wr_n = 1'b0; ad_in = 8'h99;
    cyc(4);
    chk("R9 conflict no drive", {31'd0, oe}, 32'd0);
    rd_n = 1'b1; wr_n = 1'b1;
    cyc(6);
    chk("R9 conflict no write", pulses - p0, 32'd0);

    // R9: fetch strobe overlapping only the start of a write strobe
    p0 = pulses;
    pf_n = 1'b0;
    cyc(4);
    chk("R5 fetch drives before overlap", {31'd0, oe}, 32'd1);
    wr_n = 1'b0;
    cyc(4);
    chk("R9 overlap drops drive", {31'd0, oe}, 32'd0);
    pf_n = 1'b1;
    cyc(3);
    wr_n = 1'b1;
    cyc(6);
    chk("R9 overlapped strobe no write", pulses - p0, 32'd0);

    // a clean write after the conflict still works
    do_write(15'h3C3C, 8'h42, 8'h10);

    cyc(4);
    chk("R7 scoreboard drained", exp_q.size(), 32'd0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule